// File: doc/BRIEF.md
# Per-Channel Over-Scale Flag Generator

This block turns per-conversion over-range indications from a two-channel converter into two sticky warning flags, one for the left channel and one for the right. Once per frame a one-cycle frame tick marks the moment at which each channel's latest conversion result is valid. On that tick the block samples an over-range strobe for each channel. A channel's flag goes high only when that channel has been over range on two conversions in a row. The flag then stays high for a hold window of 4096 frame periods, and it is released on the tick that completes the window.

The two channels are tracked by separate, identical logic, so activity on one never affects the other. A new qualifying pair that arrives while a flag is already high restarts that channel's hold window. Digital power-down forces both flags low and clears all tracking state. A synchronous reset does the same. The block runs on the master clock. Its outputs come straight from flops, so they can drive pins or other clock-domain logic without a glitch.

Top module: `osf_flag_gen`

## Requirements
- R1: A synchronous active-high `rst` clears both flags, both over-range runs and both hold counters; after reset both flags read 0.
- R2: An in-range conversion (tick with the channel's strobe at 0) clears that channel's run, so two over-range conversions separated by an in-range one do not raise the flag.
- R3: When a channel's strobe is 1 on two consecutive ticks, its flag reads 1 from the clock edge that samples the second of those ticks.
- R4: A raised flag stays 1 through the next 4095 ticks that do not restart it, and reads 0 after the edge that samples the 4096th such tick.
- R5: A qualifying pair completed while the flag is already 1 restarts the hold window, so the flag then lasts another 4096 ticks counted from that second tick.
- R6: Left and right are independent: `over_left` only affects `flag_left` and `over_right` only affects `flag_right`.
- R7: While `dig_pd` is 1, both flags read 0 from the next clock edge, and the runs and hold counters are cleared; after release, a single over-range tick does not raise a flag. Power-down wins over a tick in the same cycle.
- R8: The over-range strobes are ignored in cycles where `frame_tick` is 0; without a tick (and without reset or power-down) neither flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse once per frame period; marks when the strobes are sampled |
| over_left | input | 1 | Left conversion exceeded full scale (valid with `frame_tick`) |
| over_right | input | 1 | Right conversion exceeded full scale (valid with `frame_tick`) |
| dig_pd | input | 1 | Digital power-down; forces flags low and clears state |
| flag_left | output | 1 | Left over-scale flag, registered |
| flag_right | output | 1 | Right over-scale flag, registered |

## Verification
Every flag change is due on the first rising edge that samples the causing tick, power-down or reset cycle. This means an input driven at a falling edge shows at the outputs by the next falling edge. The driver records for each expected value the cycle count at which it is due. The monitor compares at the falling edge where the bench cycle counter reaches that value, so the checks never sample at an edge. The 4096-tick window is checked on every tick of the full hold, which covers the last high tick and the release tick of each window. The run-clearing, restart and power-down orderings are each placed just before or just after those boundaries.

// File: rtl/osf_pkg.sv
package osf_pkg;

  localparam int NUM_CH   = 2;
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/osf_run_detect.sv
// Counts consecutive over-range samples; signals when the run reaches RUN_LEN.
module osf_run_detect #(
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample,
  input  logic over,
  output logic qualify
);
  localparam int RW = osf_pkg::cnt_width(RUN_LEN);
  localparam logic [RW-1:0] TOP = RW'(RUN_LEN - 1);

  logic [RW-1:0] streak;

  // The sample that completes the run qualifies; later over-range samples keep qualifying.
  assign qualify = sample && over && (streak == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      streak <= '0;
    end else if (sample) begin
      if (!over) begin
        streak <= '0;
      end else if (streak != TOP) begin
        streak <= streak + RW'(1);
      end
    end
  end

endmodule

// File: rtl/osf_hold_timer.sv
// Holds the flag for HOLD steps after the last restart.
module osf_hold_timer #(
  parameter int HOLD = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic restart,
  output logic flag
);
  localparam int CW = osf_pkg::cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag    <= 1'b0;
      elapsed <= '0;
    end else if (restart) begin
      flag    <= 1'b1;
      elapsed <= '0;
    end else if (step && flag) begin
      if (elapsed == LAST) begin
        flag    <= 1'b0;
        elapsed <= '0;
      end else begin
        elapsed <= elapsed + CW'(1);
      end
    end
  end

endmodule

// File: rtl/osf_channel.sv
// One channel: run detector feeding a hold timer.
module osf_channel #(
  parameter int HOLD_FRAMES = 4096,
  parameter int RUN_LEN     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic over,
  output logic flag
);
  logic qualify;

  osf_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .sample  (tick),
    .over    (over),
    .qualify (qualify)
  );

  osf_hold_timer #(.HOLD(HOLD_FRAMES)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .step    (tick),
    .restart (qualify),
    .flag    (flag)
  );

endmodule

// File: rtl/osf_flag_gen.sv
// Top: per-channel over-scale flags with a run qualifier and a frame-counted hold.
module osf_flag_gen #(
  parameter int HOLD_FRAMES = 4096,
  parameter int RUN_LEN     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic over_left,
  input  logic over_right,
  input  logic dig_pd,
  output logic flag_left,
  output logic flag_right
);
  import osf_pkg::*;

  logic [NUM_CH-1:0] over_vec;
  logic [NUM_CH-1:0] flag_vec;

  assign over_vec[CH_LEFT]  = over_left;
  assign over_vec[CH_RIGHT] = over_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    osf_channel #(
      .HOLD_FRAMES (HOLD_FRAMES),
      .RUN_LEN     (RUN_LEN)
    ) u_ch (
      .clk  (clk),
      .rst  (rst),
      .clr  (dig_pd),
      .tick (frame_tick),
      .over (over_vec[c]),
      .flag (flag_vec[c])
    );
  end

  assign flag_left  = flag_vec[CH_LEFT];
  assign flag_right = flag_vec[CH_RIGHT];

endmodule

// File: rtl/osf_flag_chk.sv
module osf_flag_chk (
  input logic clk,
  input logic rst,
  input logic frame_tick,
  input logic over_left,
  input logic over_right,
  input logic dig_pd,
  input logic flag_left,
  input logic flag_right
);

  AST_RISE_LEFT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_left) |-> ($past(frame_tick) && $past(over_left) && !$past(dig_pd))); // R3

  AST_RISE_RIGHT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_right) |-> ($past(frame_tick) && $past(over_right) && !$past(dig_pd))); // R3

  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dig_pd |=> (!flag_left && !flag_right)); // R7

  AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && !dig_pd) |=> ($stable(flag_left) && $stable(flag_right))); // R8

  AST_DROP_LEFT: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_left) |-> ($past(frame_tick) || $past(dig_pd) || $past(rst))); // R4

  AST_DROP_RIGHT: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_right) |-> ($past(frame_tick) || $past(dig_pd) || $past(rst))); // R4

endmodule

bind osf_flag_gen osf_flag_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_tick (frame_tick),
  .over_left  (over_left),
  .over_right (over_right),
  .dig_pd     (dig_pd),
  .flag_left  (flag_left),
  .flag_right (flag_right)
);

// File: tb/tb_osf_flag_gen.sv
`timescale 1ns/1ps
module tb_osf_flag_gen;
  localparam int HOLD = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic over_left = 1'b0;
  logic over_right = 1'b0;
  logic dig_pd = 1'b0;
  logic flag_left;
  logic flag_right;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Expected-value scoreboard
  int       q_due[$];
  bit [1:0] q_exp[$];
  string    q_req[$];

  // Reference model state, per channel
  bit m_run[2];
  bit m_flag[2];
  int m_cnt[2];

  osf_flag_gen dut (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .over_left  (over_left),
    .over_right (over_right),
    .dig_pd     (dig_pd),
    .flag_left  (flag_left),
    .flag_right (flag_right)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_run[c] = 1'b0; m_flag[c] = 1'b0; m_cnt[c] = 0;
    end
  endtask

  task automatic model_tick(input int c, input bit ov);
    bit qual;
    qual = ov && m_run[c];
    m_run[c] = ov;
    if (qual) begin
      m_flag[c] = 1'b1; m_cnt[c] = 0;
    end else if (m_flag[c]) begin
      if (m_cnt[c] == HOLD - 1) begin
        m_flag[c] = 1'b0; m_cnt[c] = 0;
      end else begin
        m_cnt[c]++;
      end
    end
  endtask

  // Driver: drives one cycle of inputs at a falling edge and queues the expected flags.
  task automatic apply(input bit r, input bit pd, input bit tk, input bit ol,
                       input bit orr, input string req);
    rst = r; dig_pd = pd; frame_tick = tk; over_left = ol; over_right = orr;
    if (r || pd) model_clear();
    else if (tk) begin
      model_tick(0, ol);
      model_tick(1, orr);
    end
    q_due.push_back(cyc + 1);
    q_exp.push_back({m_flag[0], m_flag[1]});
    q_req.push_back(req);
    @(negedge clk);
  endtask

  task automatic frame(input bit ol, input bit orr, input string req);
    apply(1'b0, 1'b0, 1'b1, ol, orr, req);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  // Monitor: compares outputs at the falling edge where each item is due.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      checks++;
      if (q_due[0] != cyc || {flag_left, flag_right} !== q_exp[0]) begin
        errors++;
        $display("FAIL %s cycle %0d: flags(l,r)=%b expected %b", q_req[0], cyc,
                 {flag_left, flag_right}, q_exp[0]);
      end
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_req.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    // R1: reset state
    repeat (3) apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R2: separated over-range conversions never set the flag
    frame(1, 1, "R2"); frame(0, 0, "R2"); frame(1, 1, "R2"); frame(0, 0, "R2");

    // R8: strobes without a tick are ignored; one over tick after them must not qualify
    repeat (4) apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    frame(1, 0, "R8"); frame(0, 0, "R8");

    // R3 and R6: left pair sets only the left flag
    frame(1, 0, "R3"); frame(1, 0, "R6");
    repeat (5) apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");

    // R4: full hold window, boundary at the 4096th tick
    for (int i = 0; i < HOLD + 3; i++) frame(0, 0, "R4");

    // R5: restart partway through the window
    frame(1, 0, "R5"); frame(1, 0, "R5");
    for (int i = 0; i < 2000; i++) frame(0, 0, "R5");
    frame(1, 0, "R5"); frame(1, 0, "R5");
    for (int i = 0; i < HOLD + 2; i++) frame(0, 0, "R5");

    // R6: interleaved strobes; only right has a consecutive pair
    frame(1, 0, "R6"); frame(0, 1, "R6"); frame(1, 1, "R6"); frame(0, 0, "R6");

    // R7: power-down clears flags and runs; power-down beats a tick
    frame(1, 1, "R7");
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    frame(1, 1, "R7"); frame(0, 0, "R7");
    frame(1, 1, "R7"); frame(1, 1, "R7");

    // R1: mid-run reset clears flags and runs
    frame(1, 1, "R1");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    frame(1, 1, "R1"); frame(0, 0, "R1");

    repeat (3) @(negedge clk);
    if (q_due.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_due.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule